// File: doc/BRIEF.md
# Three-Wire Serial Command Port

This block is the slave side of a three-line serial port in front of a pair of 32-bit seconds counters and an oscillator trim register. The three lines are an active-high transaction enable, a serial clock and one data line. All three are sampled into the system clock domain. Edges of the serial clock are found there, so the port has no logic clocked by the serial clock. The data line is bidirectional at the pad. The block drives it through a data output and an output-enable, and it reads the pad value on a separate input.

Each transaction begins with an 8-bit command byte. One bit selects the continuous counter and another selects the supply-active counter. A 3-bit field carries a trim value, two bits request clears, and one bit picks read or write. The command byte may lead to a 32-bit write, a 32-bit read of a snapshot, a trim update, or clears that take effect when the transaction closes. The counter core acts on single-cycle strobes and reads the load data from the block. The block also takes both counter values as inputs, so that it can snapshot them.

Top module: `serial_cmd_port`

## Requirements
- R1: After reset, and on every cycle that follows a cycle in which the synchronised enable is low, the output-enable is 0. No strobe is raised while the port is idle.
- R2: The command byte is taken from 8 rising serial-clock edges, least significant bit first. Bit 7 selects the continuous counter, bit 6 selects the supply-active counter, bits 5..3 hold the trim value, bit 2 requests a clear of the continuous counter, bit 1 requests a clear of the supply-active counter, and bit 0 chooses read (1) or write (0).
- R3: If exactly one of bits 7 and 6 is set and bit 0 is 0, the next 32 rising edges shift in a data word, least significant bit first. The load strobe of the selected counter then pulses once, with that word on the load data output.
- R4: After the 32nd write bit, further serial clocks in the same transaction cause no strobe and do not change the loaded word.
- R5: If exactly one of bits 7 and 6 is set and bit 0 is 1, the snapshot strobe pulses once when the command byte completes, and the selected counter value is captured. Bit i of the capture is driven on the data line during the low phase that follows falling edge i+1 after the last command bit.
- R6: The output-enable is high only during the low phase of the serial clock in a read. It is low while the serial clock is high, and it falls once the enable drops.
- R7: If bits 7 and 6 are both 1, the trim-update strobe pulses once with bits 5..3 as the trim value. Later clocks in that transaction raise no strobe.
- R8: If bits 7 and 6 are both 0, the clears requested by bits 2 and 1 are issued only when the enable falls, and both may be issued together.
- R9: If the enable falls before the 8th command bit, or before the 32nd write bit, no strobe at all is issued for that transaction.
- R10: While the power-good input is low, the port is held idle. No strobe is raised and the data line is not driven.
- R11: Every strobe lasts one system clock cycle, and no two of load, snapshot, trim and clear are raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good_i | input | 1 | Main power good; low disables the port |
| ser_en_i | input | 1 | Serial transaction enable, active high, asynchronous |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Data line value seen at the pad |
| ser_dat_o | output | 1 | Data line value to drive during a read |
| ser_dat_oe_o | output | 1 | Drive enable for the data line pad |
| cont_cnt_i | input | 32 | Present value of the continuous counter |
| actv_cnt_i | input | 32 | Present value of the supply-active counter |
| load_data_o | output | 32 | Word to load into a counter |
| load_cont_o | output | 1 | Load strobe for the continuous counter |
| load_actv_o | output | 1 | Load strobe for the supply-active counter |
| snap_o | output | 1 | Snapshot strobe, marks the capture of a counter for reading |
| clr_cont_o | output | 1 | Clear strobe for the continuous counter |
| clr_actv_o | output | 1 | Clear strobe for the supply-active counter |
| trim_we_o | output | 1 | Trim register update strobe |
| trim_val_o | output | 3 | Trim value presented with the update strobe |

## Verification
The assertions check four rules on every cycle: the data line is driven only after a low serial-clock sample, the pad is released once the enable or the power-good input drops, clears appear only right after the enable falls, and strobes are single and mutually exclusive. The bench scenarios are needed for the rest. They show the bit order of command and data, which counter a given command byte reaches, the value that is loaded or read back, the trim value, that extra clocks and short commands are ignored, and the hold-off of clears until the end of the transaction.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int CMD_W  = 8;
  localparam int TRIM_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_SKIP
  } scp_state_e;

  // Field order follows the command bit positions, MSB first.
  typedef struct packed {
    logic              sel_cont;
    logic              sel_actv;
    logic [TRIM_W-1:0] trim;
    logic              clr_cont;
    logic              clr_actv;
    logic              rd;
  } scp_cmd_t;

  function automatic scp_cmd_t scp_decode(logic [CMD_W-1:0] raw);
    return scp_cmd_t'(raw);
  endfunction

endpackage

// File: rtl/scp_rst_sync.sv
module scp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = stage_q[STAGES-1];

endmodule

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end

    assign lvl_o[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= lvl_o;
  end

endmodule

// File: rtl/scp_engine.sv
module scp_engine
  import scp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              en_lvl_i,
  input  logic              sclk_lvl_i,
  input  logic              sclk_prev_i,
  input  logic              din_lvl_i,
  input  logic [DATA_W-1:0] cont_cnt_i,
  input  logic [DATA_W-1:0] actv_cnt_i,
  output logic              dout_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              load_cont_o,
  output logic              load_actv_o,
  output logic              snap_o,
  output logic              clr_cont_o,
  output logic              clr_actv_o,
  output logic              trim_we_o,
  output logic [TRIM_W-1:0] trim_val_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  scp_state_e        state_q, state_n;
  logic [CNT_W-1:0]  bit_q, bit_n;
  logic [CMD_W-2:0]  cmd_q, cmd_n;
  logic [DATA_W-1:0] shreg_q, shreg_n;
  logic              tgt_cont_q, tgt_cont_n;
  logic              pend_cont_q, pend_cont_n;
  logic              pend_actv_q, pend_actv_n;
  logic              dout_q, dout_n;
  logic              oe_q, oe_n;
  logic              ldc_q, ldc_n, lda_q, lda_n;
  logic              snap_q, snap_n;
  logic              clrc_q, clrc_n, clra_q, clra_n;
  logic              trim_we_q, trim_we_n;
  logic [TRIM_W-1:0] trim_q, trim_n;

  logic     active, sclk_rise, sclk_fall;
  scp_cmd_t dec;

  assign active    = en_lvl_i & pwr_good_i;
  assign sclk_rise = sclk_lvl_i & ~sclk_prev_i;
  assign sclk_fall = ~sclk_lvl_i & sclk_prev_i;
  assign dec       = scp_decode({din_lvl_i, cmd_q});

  always_comb begin
    state_n     = state_q;
    bit_n       = bit_q;
    cmd_n       = cmd_q;
    shreg_n     = shreg_q;
    tgt_cont_n  = tgt_cont_q;
    pend_cont_n = pend_cont_q;
    pend_actv_n = pend_actv_q;
    dout_n      = dout_q;
    oe_n        = oe_q & ~sclk_lvl_i;
    ldc_n       = 1'b0;
    lda_n       = 1'b0;
    snap_n      = 1'b0;
    clrc_n      = 1'b0;
    clra_n      = 1'b0;
    trim_we_n   = 1'b0;
    trim_n      = trim_q;

    unique case (state_q)
      ST_IDLE: begin
        if (active) begin
          state_n     = ST_CMD;
          bit_n       = '0;
          pend_cont_n = 1'b0;
          pend_actv_n = 1'b0;
        end
      end
      ST_CMD: begin
        if (sclk_rise) begin
          cmd_n = {din_lvl_i, cmd_q[CMD_W-2:1]};
          bit_n = bit_q + 1'b1;
          if (bit_q == CNT_W'(CMD_W - 1)) begin
            bit_n = '0;
            if (dec.sel_cont && dec.sel_actv) begin
              trim_we_n = 1'b1;
              trim_n    = dec.trim;
              state_n   = ST_SKIP;
            end else if (dec.sel_cont || dec.sel_actv) begin
              tgt_cont_n = dec.sel_cont;
              if (dec.rd) begin
                shreg_n = dec.sel_cont ? cont_cnt_i : actv_cnt_i;
                snap_n  = 1'b1;
                state_n = ST_RD;
              end else begin
                state_n = ST_WR;
              end
            end else begin
              pend_cont_n = dec.clr_cont;
              pend_actv_n = dec.clr_actv;
              state_n     = ST_SKIP;
            end
          end
        end
      end
      ST_WR: begin
        if (sclk_rise) begin
          shreg_n = {din_lvl_i, shreg_q[DATA_W-1:1]};
          bit_n   = bit_q + 1'b1;
          if (bit_q == CNT_W'(DATA_W - 1)) begin
            ldc_n   = tgt_cont_q;
            lda_n   = ~tgt_cont_q;
            state_n = ST_SKIP;
          end
        end
      end
      ST_RD: begin
        if (sclk_fall) begin
          if (bit_q == CNT_W'(DATA_W)) begin
            oe_n    = 1'b0;
            state_n = ST_SKIP;
          end else begin
            dout_n  = shreg_q[0];
            shreg_n = {1'b0, shreg_q[DATA_W-1:1]};
            oe_n    = 1'b1;
            bit_n   = bit_q + 1'b1;
          end
        end
      end
      ST_SKIP: begin
      end
      default: state_n = ST_IDLE;
    endcase

    // Leaving the transaction overrides everything decided above.
    if (!active) begin
      state_n   = ST_IDLE;
      oe_n      = 1'b0;
      ldc_n     = 1'b0;
      lda_n     = 1'b0;
      snap_n    = 1'b0;
      trim_we_n = 1'b0;
      trim_n    = trim_q;
      if (state_q == ST_SKIP && pwr_good_i) begin
        clrc_n = pend_cont_q;
        clra_n = pend_actv_q;
      end
      pend_cont_n = 1'b0;
      pend_actv_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_q       <= '0;
      cmd_q       <= '0;
      shreg_q     <= '0;
      tgt_cont_q  <= 1'b0;
      pend_cont_q <= 1'b0;
      pend_actv_q <= 1'b0;
      dout_q      <= 1'b0;
      oe_q        <= 1'b0;
      ldc_q       <= 1'b0;
      lda_q       <= 1'b0;
      snap_q      <= 1'b0;
      clrc_q      <= 1'b0;
      clra_q      <= 1'b0;
      trim_we_q   <= 1'b0;
      trim_q      <= '0;
    end else begin
      state_q     <= state_n;
      bit_q       <= bit_n;
      cmd_q       <= cmd_n;
      shreg_q     <= shreg_n;
      tgt_cont_q  <= tgt_cont_n;
      pend_cont_q <= pend_cont_n;
      pend_actv_q <= pend_actv_n;
      dout_q      <= dout_n;
      oe_q        <= oe_n;
      ldc_q       <= ldc_n;
      lda_q       <= lda_n;
      snap_q      <= snap_n;
      clrc_q      <= clrc_n;
      clra_q      <= clra_n;
      trim_we_q   <= trim_we_n;
      trim_q      <= trim_n;
    end
  end

  assign dout_o      = dout_q;
  assign oe_o        = oe_q;
  assign load_data_o = shreg_q;
  assign load_cont_o = ldc_q;
  assign load_actv_o = lda_q;
  assign snap_o      = snap_q;
  assign clr_cont_o  = clrc_q;
  assign clr_actv_o  = clra_q;
  assign trim_we_o   = trim_we_q;
  assign trim_val_o  = trim_q;

endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
  import scp_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              ser_en_i,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  output logic              ser_dat_o,
  output logic              ser_dat_oe_o,
  input  logic [DATA_W-1:0] cont_cnt_i,
  input  logic [DATA_W-1:0] actv_cnt_i,
  output logic [DATA_W-1:0] load_data_o,
  output logic              load_cont_o,
  output logic              load_actv_o,
  output logic              snap_o,
  output logic              clr_cont_o,
  output logic              clr_actv_o,
  output logic              trim_we_o,
  output logic [TRIM_W-1:0] trim_val_o
);

  localparam int N_SER = 3;

  logic             rst_sn;
  logic [N_SER-1:0] ser_lvl, ser_prev;
  logic             en_lvl, sclk_lvl, sclk_prev, din_lvl;

  scp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sn)
  );

  scp_sync #(.WIDTH(N_SER), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_sn),
    .async_i ({ser_dat_i, ser_clk_i, ser_en_i}),
    .lvl_o   (ser_lvl),
    .prev_o  (ser_prev)
  );

  assign en_lvl    = ser_lvl[0];
  assign sclk_lvl  = ser_lvl[1];
  assign sclk_prev = ser_prev[1];
  assign din_lvl   = ser_lvl[2];

  scp_engine #(.DATA_W(DATA_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_sn),
    .pwr_good_i  (pwr_good_i),
    .en_lvl_i    (en_lvl),
    .sclk_lvl_i  (sclk_lvl),
    .sclk_prev_i (sclk_prev),
    .din_lvl_i   (din_lvl),
    .cont_cnt_i  (cont_cnt_i),
    .actv_cnt_i  (actv_cnt_i),
    .dout_o      (ser_dat_o),
    .oe_o        (ser_dat_oe_o),
    .load_data_o (load_data_o),
    .load_cont_o (load_cont_o),
    .load_actv_o (load_actv_o),
    .snap_o      (snap_o),
    .clr_cont_o  (clr_cont_o),
    .clr_actv_o  (clr_actv_o),
    .trim_we_o   (trim_we_o),
    .trim_val_o  (trim_val_o)
  );

endmodule

// File: rtl/scp_chk.sv
module scp_chk (
  input logic clk_i,
  input logic rst_n,
  input logic pwr_good_i,
  input logic en_lvl,
  input logic sclk_lvl,
  input logic ser_dat_oe_o,
  input logic load_cont_o,
  input logic load_actv_o,
  input logic snap_o,
  input logic clr_cont_o,
  input logic clr_actv_o,
  input logic trim_we_o
);

  // R6
  oe_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ser_dat_oe_o |-> $past(!sclk_lvl));

  // R1
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_lvl |=> !ser_dat_oe_o);

  // R10
  pwr_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !pwr_good_i |=> !(ser_dat_oe_o || load_cont_o || load_actv_o || snap_o ||
                      clr_cont_o || clr_actv_o || trim_we_o));

  // R8
  clr_at_close_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (clr_cont_o || clr_actv_o) |-> ($past(!en_lvl) && $past(en_lvl, 2)));

  // R3
  load_in_txn_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (load_cont_o || load_actv_o) |-> $past(en_lvl));

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({load_cont_o, load_actv_o, snap_o, trim_we_o, clr_cont_o | clr_actv_o}));

  // R11
  load_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (load_cont_o || load_actv_o) |=> !(load_cont_o || load_actv_o));

  // R11
  snap_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    snap_o |=> !snap_o);

  // R7
  trim_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    trim_we_o |=> !trim_we_o);

endmodule

bind serial_cmd_port scp_chk u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_sn),
  .pwr_good_i   (pwr_good_i),
  .en_lvl       (en_lvl),
  .sclk_lvl     (sclk_lvl),
  .ser_dat_oe_o (ser_dat_oe_o),
  .load_cont_o  (load_cont_o),
  .load_actv_o  (load_actv_o),
  .snap_o       (snap_o),
  .clr_cont_o   (clr_cont_o),
  .clr_actv_o   (clr_actv_o),
  .trim_we_o    (trim_we_o)
);

// File: tb/serial_cmd_port_bench.sv
module serial_cmd_port_bench;

  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_good = 1'b1;
  logic        s_en = 1'b0;
  logic        s_clk = 1'b1;
  logic        s_din = 1'b0;
  logic        dq_o, dq_oe;
  logic [31:0] cont_val = 32'hA5C3_0F18;
  logic [31:0] actv_val = 32'h1234_5678;
  logic [31:0] ld_data;
  logic        ld_cont, ld_actv, snap, clr_c, clr_a, trim_we;
  logic [2:0]  trim_val;

  int checks = 0;
  int failures = 0;
  int n_ldc = 0, n_lda = 0, n_snap = 0, n_clrc = 0, n_clra = 0, n_trim = 0;
  logic [31:0] last_ld = '0;
  logic [2:0]  last_trim = '0;

  always #5 clk = ~clk;

  serial_cmd_port u_serial_cmd_port (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pwr_good_i   (pwr_good),
    .ser_en_i     (s_en),
    .ser_clk_i    (s_clk),
    .ser_dat_i    (s_din),
    .ser_dat_o    (dq_o),
    .ser_dat_oe_o (dq_oe),
    .cont_cnt_i   (cont_val),
    .actv_cnt_i   (actv_val),
    .load_data_o  (ld_data),
    .load_cont_o  (ld_cont),
    .load_actv_o  (ld_actv),
    .snap_o       (snap),
    .clr_cont_o   (clr_c),
    .clr_actv_o   (clr_a),
    .trim_we_o    (trim_we),
    .trim_val_o   (trim_val)
  );

  always @(negedge clk) begin
    if (ld_cont) begin n_ldc++; last_ld = ld_data; end
    if (ld_actv) begin n_lda++; last_ld = ld_data; end
    if (snap)    n_snap++;
    if (clr_c)   n_clrc++;
    if (clr_a)   n_clra++;
    if (trim_we) begin n_trim++; last_trim = trim_val; end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic zero_counts();
    n_ldc = 0; n_lda = 0; n_snap = 0; n_clrc = 0; n_clra = 0; n_trim = 0;
  endtask

  task automatic begin_txn();
    zero_counts();
    s_clk = 1'b1;
    s_en  = 1'b1;
    tick(H);
  endtask

  task automatic end_txn();
    s_en = 1'b0;
    tick(H);
  endtask

  task automatic send_bit(logic b);
    s_clk = 1'b0;
    s_din = b;
    tick(H);
    s_clk = 1'b1;
    tick(H);
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  // Reads n bits; counts phases where the drive enable is wrong.
  task automatic read_bits(int n, output logic [31:0] word, output int bad_oe);
    word = '0;
    bad_oe = 0;
    for (int i = 0; i < n; i++) begin
      s_clk = 1'b0;
      tick(H);
      word[i] = dq_o;
      if (dq_oe !== 1'b1) bad_oe++;
      s_clk = 1'b1;
      tick(H);
      if (dq_oe !== 1'b0) bad_oe++;
    end
  endtask

  task automatic t_reset();
    tick(2);
    chk("R1", "oe in reset", {31'b0, dq_oe}, 32'd0);
    rst_n = 1'b1;
    tick(2 * H);
    chk("R1", "oe idle", {31'b0, dq_oe}, 32'd0);
    chk("R1", "strobes idle", n_ldc + n_lda + n_snap + n_clrc + n_clra + n_trim, 32'd0);
  endtask

  task automatic t_write(logic sel_cont, logic [31:0] w, int extra);
    begin_txn();
    send_bits(sel_cont ? 32'h80 : 32'h40, 8);
    send_bits(w, 32);
    for (int i = 0; i < extra; i++) send_bit(1'b1);
    chk("R3", "load selected", sel_cont ? n_ldc : n_lda, 32'd1);
    chk("R3", "load other", sel_cont ? n_lda : n_ldc, 32'd0);
    chk("R3", "load word", last_ld, w);
    if (extra > 0) chk("R4", "extra clocks no strobe",
                       n_snap + n_trim + n_ldc + n_lda, 32'd1);
    end_txn();
    chk("R4", "no late strobe", n_ldc + n_lda + n_clrc + n_clra, 32'd1);
  endtask

  task automatic t_read(logic sel_cont);
    logic [31:0] word;
    int bad;
    begin_txn();
    send_bits(sel_cont ? 32'h81 : 32'h41, 8);
    chk("R5", "snapshot pulse", n_snap, 32'd1);
    chk("R6", "oe high phase after cmd", {31'b0, dq_oe}, 32'd0);
    read_bits(32, word, bad);
    chk("R5", "read word", word, sel_cont ? cont_val : actv_val);
    chk("R6", "oe phase errors", bad, 32'd0);
    s_clk = 1'b0;
    tick(H);
    chk("R6", "no drive after 32 bits", {31'b0, dq_oe}, 32'd0);
    s_clk = 1'b1;
    tick(H);
    end_txn();
    chk("R5", "read no loads", n_ldc + n_lda + n_clrc + n_clra + n_trim, 32'd0);
  endtask

  task automatic t_read_abort();
    logic [31:0] word;
    int bad;
    begin_txn();
    send_bits(32'h81, 8);
    read_bits(3, word, bad);
    s_clk = 1'b0;
    tick(H);
    chk("R6", "oe low phase mid read", {31'b0, dq_oe}, 32'd1);
    s_en = 1'b0;
    tick(H);
    chk("R6", "oe after enable drop", {31'b0, dq_oe}, 32'd0);
    s_clk = 1'b1;
    tick(H);
    chk("R5", "partial read bits", word[2:0], cont_val[2:0]);
  endtask

  task automatic t_trim(logic [2:0] tv);
    begin_txn();
    send_bits({24'b0, 2'b11, tv, 3'b110}, 8);
    send_bits(32'h0000_FFFF, 16);
    chk("R7", "trim pulse", n_trim, 32'd1);
    chk("R7", "trim value", {29'b0, last_trim}, {29'b0, tv});
    end_txn();
    chk("R7", "trim no other strobe", n_ldc + n_lda + n_snap + n_clrc + n_clra, 32'd0);
  endtask

  task automatic t_clear(logic cc, logic ca);
    begin_txn();
    send_bits({24'b0, 5'b00111, cc, ca, 1'b1}, 8);
    send_bits(32'hF, 4);
    chk("R8", "no clear before close", n_clrc + n_clra, 32'd0);
    end_txn();
    chk("R8", "clear cont", n_clrc, {31'b0, cc});
    chk("R8", "clear actv", n_clra, {31'b0, ca});
  endtask

  task automatic t_short_cmd();
    begin_txn();
    send_bits(32'h06, 5);
    end_txn();
    chk("R9", "short command strobes", n_ldc + n_lda + n_snap + n_clrc + n_clra + n_trim, 32'd0);
    begin_txn();
    send_bits(32'h40, 8);
    send_bits(32'hFFFF_FFFF, 16);
    end_txn();
    chk("R9", "aborted write strobes", n_ldc + n_lda + n_snap + n_clrc + n_clra + n_trim, 32'd0);
  endtask

  task automatic t_pwr_off();
    pwr_good = 1'b0;
    begin_txn();
    send_bits(32'h81, 8);
    s_clk = 1'b0;
    tick(H);
    chk("R10", "no drive without power", {31'b0, dq_oe}, 32'd0);
    s_clk = 1'b1;
    tick(H);
    end_txn();
    begin_txn();
    send_bits(32'h06, 8);
    end_txn();
    chk("R10", "no strobes without power", n_ldc + n_lda + n_snap + n_clrc + n_clra + n_trim, 32'd0);
    pwr_good = 1'b1;
    tick(H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_write(1'b1, 32'hDEAD_BEEF, 0);
    t_write(1'b0, 32'h0F0F_1234, 0);
    t_write(1'b1, 32'h8000_0001, 3);
    t_read(1'b1);
    t_read(1'b0);
    t_read_abort();
    t_trim(3'd5);
    t_trim(3'd2);
    t_clear(1'b1, 1'b1);
    t_clear(1'b1, 1'b0);
    t_clear(1'b0, 1'b1);
    t_short_cmd();
    t_pwr_off();
    // R2: command bit order confirmed again after the power test
    t_write(1'b0, 32'h5555_AAAA, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule